// File: doc/BRIEF.md
# Packet Fragment Capture Buffer

This block sits at the end of a byte-wide streaming datapath and holds one packet fragment at a time for a host processor. Each incoming byte arrives with a logical channel number, start-of-packet and end-of-packet markers, an end-of-fragment marker and three error indications. The block stores the payload bytes and builds a small header that records the fragment's flags, its length and its channel. When the fragment is complete, the block sets a data-available flag and sends a single-cycle capture event to the interrupt logic.

While the flag is set, the stream side is held off and the block keeps the stored fragment unchanged. The host reads the header and the payload through a read port with one cycle of latency, then clears the flag with a one-cycle release strobe. The release hands the buffer back to the stream side.

The control is a three-state machine. `ST_IDLE` waits for the first byte of a fragment. `ST_FILL` accepts the following bytes. `ST_HELD` belongs to the host. The transitions are:
- `IDLE->FILL`: the first byte is accepted and is not the final byte.
- `IDLE->HELD`: a one-byte fragment.
- `FILL->HELD`: the final byte is accepted.
- `HELD->IDLE`: the host releases the buffer.

Top module: `frag_capture_mbox`

## Requirements
- R1: After reset, `s_ready` is 1, `data_avail` is 0 and `cap_event` is 0.
- R2: The payload byte accepted in position i of a fragment (i counts from 0) reads back at host address 3+i. `h_rd_data` shows the value in the cycle after the cycle in which `h_rd_en` was sampled high.
- R3: A byte accepted with `s_last` or `s_eop` high ends the fragment. The length byte at address 1 then reads as the byte count minus one, so a one-byte fragment reads 0x00.
- R4: A fragment that reaches 256 bytes ends on the 256th byte even when no end marker was given. Its length byte reads 0xFF.
- R5: In the cycle after the final byte is accepted, `cap_event` is high for exactly one cycle, and `data_avail` rises in that same cycle.
- R6: While `data_avail` is 1, `s_ready` is 0. Bytes offered on the stream change neither the payload nor the header.
- R7: Address 2 reads the channel number sampled with the first byte of the fragment.
- R8: The flags byte at address 0 has SOP in bit 0, EOP in bit 1, address parity error in bit 2, data parity error in bit 3 and packet error in bit 4. Bits 7 to 5 read as 0. Each flag is the OR of that input over all bytes of the fragment.
- R9: A `h_clr` pulse while `data_avail` is 1 makes `data_avail` 0 and `s_ready` 1 in the next cycle. It also clears the accumulated flags, so the next fragment reports only its own flags.
- R10: `h_clr` while `data_avail` is 0 has no effect: a fragment being filled completes normally.
- R11: A read while `data_avail` is 0 returns 0x00.
- R12: A read at any address above 258 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Block can accept a stream byte |
| s_data | input | 8 | Stream payload byte |
| s_chan | input | 8 | Logical channel number of the fragment |
| s_sop | input | 1 | Start-of-packet marker |
| s_eop | input | 1 | End-of-packet marker (also ends the fragment) |
| s_last | input | 1 | End-of-fragment marker |
| s_addr_perr | input | 1 | Address parity error indication |
| s_data_perr | input | 1 | Data parity error indication |
| s_pkt_err | input | 1 | Packet error indication |
| h_rd_en | input | 1 | Host read strobe |
| h_rd_addr | input | 9 | Host read address: 0 flags, 1 length, 2 channel, 3..258 payload |
| h_rd_data | output | 8 | Registered host read data |
| h_clr | input | 1 | Host release strobe that clears data-available |
| data_avail | output | 1 | Fragment stored and owned by the host |
| cap_event | output | 1 | One-cycle capture event toward the interrupt logic |

## Verification
The hardest case to reach from the ports is completion on the byte count alone. A fragment has to run for the full 256 bytes with no end marker, and the last index must both be written and be reported as length 0xFF. The bench drives exactly 256 back-to-back bytes with the markers held low, then reads the first and last payload bytes and the length byte. A second hard case is a release strobe that arrives during filling. The bench asserts `h_clr` in the middle of a fragment and then checks that the fragment still completes with the correct length. The bench also sends a fragment with no flags right after one that carried SOP and EOP, which shows that the sticky flags were cleared by the release.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_HELD = 2'd2
    } fcap_state_e;

    // Packed so that sop lands in bit 0 and pkt_err in bit 4
    typedef struct packed {
        logic pkt_err;
        logic data_perr;
        logic addr_perr;
        logic eop;
        logic sop;
    } fcap_flags_t;

    localparam int HDR_BYTES   = 3;
    localparam int HDR_FLAGS   = 0;
    localparam int HDR_LENGTH  = 1;
    localparam int HDR_CHANNEL = 2;

endpackage

// File: rtl/fcap_fsm.sv
module fcap_fsm
    import fcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        beat,
    input  logic        beat_end,
    input  logic        host_clr,
    output fcap_state_e state,
    output logic        complete,
    output logic        release_buf,
    output logic        cap_event
);

    fcap_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (beat) begin
                    state_nx = beat_end ? ST_HELD : ST_FILL;
                end
            end
            ST_FILL: begin
                if (beat && beat_end) begin
                    state_nx = ST_HELD;
                end
            end
            ST_HELD: begin
                if (host_clr) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign complete    = beat && beat_end && (state != ST_HELD);
    assign release_buf = (state == ST_HELD) && host_clr;

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_event <= 1'b0;
        end else begin
            cap_event <= complete;
        end
    end

endmodule

// File: rtl/fcap_store.sv
module fcap_store #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/fcap_meta.sv
module fcap_meta
    import fcap_pkg::*;
#(
    parameter int MAX_BYTES = 256,
    parameter int CHAN_W    = 8,
    localparam int IDX_W    = $clog2(MAX_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat,
    input  logic              first_beat,
    input  logic              complete,
    input  logic              release_buf,
    input  logic [CHAN_W-1:0] in_chan,
    input  fcap_flags_t       in_flags,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              idx_full,
    output logic [IDX_W-1:0]  len_q,
    output logic [CHAN_W-1:0] chan_q,
    output fcap_flags_t       flags_q
);

    assign idx_full = (wr_idx == IDX_W'(MAX_BYTES - 1));

    // byte position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
        end else if (complete) begin
            wr_idx <= '0;
        end else if (beat) begin
            wr_idx <= wr_idx + 1'b1;
        end
    end

    // length in count-minus-one form
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (complete) begin
            len_q <= wr_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
        end else if (beat && first_beat) begin
            chan_q <= in_chan;
        end
    end

    // sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (release_buf) begin
            flags_q <= '0;
        end else if (beat) begin
            flags_q <= flags_q | in_flags;
        end
    end

endmodule

// File: rtl/frag_capture_mbox.sv
module frag_capture_mbox
    import fcap_pkg::*;
#(
    parameter int MAX_BYTES = 256,
    parameter int DATA_W    = 8,
    parameter int CHAN_W    = 8,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int ADDR_W   = $clog2(MAX_BYTES + HDR_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic [CHAN_W-1:0] s_chan,
    input  logic              s_sop,
    input  logic              s_eop,
    input  logic              s_last,
    input  logic              s_addr_perr,
    input  logic              s_data_perr,
    input  logic              s_pkt_err,
    input  logic              h_rd_en,
    input  logic [ADDR_W-1:0] h_rd_addr,
    output logic [DATA_W-1:0] h_rd_data,
    input  logic              h_clr,
    output logic              data_avail,
    output logic              cap_event
);

    fcap_state_e       state;
    logic              beat;
    logic              beat_end;
    logic              complete;
    logic              release_buf;
    logic [IDX_W-1:0]  wr_idx;
    logic              idx_full;
    logic [IDX_W-1:0]  len_q;
    logic [CHAN_W-1:0] chan_q;
    fcap_flags_t       flags_q;
    fcap_flags_t       in_flags;
    logic [ADDR_W-1:0] pay_off;
    logic              pay_hit;
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] rd_mux;

    assign s_ready    = (state != ST_HELD);
    assign data_avail = (state == ST_HELD);
    assign beat       = s_valid && s_ready;
    assign beat_end   = s_last || s_eop || idx_full;

    always_comb begin
        in_flags           = '0;
        in_flags.sop       = s_sop;
        in_flags.eop       = s_eop;
        in_flags.addr_perr = s_addr_perr;
        in_flags.data_perr = s_data_perr;
        in_flags.pkt_err   = s_pkt_err;
    end

    fcap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat),
        .beat_end    (beat_end),
        .host_clr    (h_clr),
        .state       (state),
        .complete    (complete),
        .release_buf (release_buf),
        .cap_event   (cap_event)
    );

    fcap_meta #(
        .MAX_BYTES (MAX_BYTES),
        .CHAN_W    (CHAN_W)
    ) u_meta (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat),
        .first_beat  (state == ST_IDLE),
        .complete    (complete),
        .release_buf (release_buf),
        .in_chan     (s_chan),
        .in_flags    (in_flags),
        .wr_idx      (wr_idx),
        .idx_full    (idx_full),
        .len_q       (len_q),
        .chan_q      (chan_q),
        .flags_q     (flags_q)
    );

    assign pay_off = h_rd_addr - ADDR_W'(HDR_BYTES);
    assign pay_hit = (h_rd_addr >= ADDR_W'(HDR_BYTES)) &&
                     (pay_off < ADDR_W'(MAX_BYTES));

    fcap_store #(
        .DEPTH (MAX_BYTES),
        .DW    (DATA_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (beat),
        .wr_idx  (wr_idx),
        .wr_data (s_data),
        .rd_idx  (pay_off[IDX_W-1:0]),
        .rd_data (mem_rd)
    );

    always_comb begin
        rd_mux = '0;
        if (data_avail) begin
            if (h_rd_addr == ADDR_W'(HDR_FLAGS)) begin
                rd_mux = DATA_W'(flags_q);
            end else if (h_rd_addr == ADDR_W'(HDR_LENGTH)) begin
                rd_mux = DATA_W'(len_q);
            end else if (h_rd_addr == ADDR_W'(HDR_CHANNEL)) begin
                rd_mux = DATA_W'(chan_q);
            end else if (pay_hit) begin
                rd_mux = mem_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rd_data <= '0;
        end else if (h_rd_en) begin
            h_rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/fcap_checker.sv
module fcap_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              h_clr,
    input logic              h_rd_en,
    input logic [DATA_W-1:0] h_rd_data,
    input logic              data_avail,
    input logic              cap_event
);

    a_r6_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        data_avail |-> !s_ready);

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && !h_clr) |=> data_avail);

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_event |=> !cap_event);

    a_r5_event_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_event) |-> $rose(data_avail));

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (data_avail && h_clr) |=> (!data_avail && s_ready));

    a_r11_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd_en && !data_avail) |=> (h_rd_data == '0));

endmodule

bind frag_capture_mbox fcap_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_ready    (s_ready),
    .h_clr      (h_clr),
    .h_rd_en    (h_rd_en),
    .h_rd_data  (h_rd_data),
    .data_avail (data_avail),
    .cap_event  (cap_event)
);

// File: tb/sim_frag_capture_mbox.sv
module sim_frag_capture_mbox;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0;
    logic       s_ready;
    logic [7:0] s_data = '0;
    logic [7:0] s_chan = '0;
    logic       s_sop = 1'b0;
    logic       s_eop = 1'b0;
    logic       s_last = 1'b0;
    logic       s_addr_perr = 1'b0;
    logic       s_data_perr = 1'b0;
    logic       s_pkt_err = 1'b0;
    logic       h_rd_en = 1'b0;
    logic [8:0] h_rd_addr = '0;
    logic [7:0] h_rd_data;
    logic       h_clr = 1'b0;
    logic       data_avail;
    logic       cap_event;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    frag_capture_mbox u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_chan(s_chan), .s_sop(s_sop), .s_eop(s_eop),
        .s_last(s_last), .s_addr_perr(s_addr_perr), .s_data_perr(s_data_perr),
        .s_pkt_err(s_pkt_err), .h_rd_en(h_rd_en), .h_rd_addr(h_rd_addr),
        .h_rd_data(h_rd_data), .h_clr(h_clr), .data_avail(data_avail),
        .cap_event(cap_event)
    );

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed ^ 8'(i * 13) ^ 8'(i >> 3);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [7:0] ch, input logic sop,
                        input logic eop, input logic last, input logic [2:0] err);
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_chan = ch; s_sop = sop; s_eop = eop;
        s_last = last; s_addr_perr = err[0]; s_data_perr = err[1]; s_pkt_err = err[2];
        @(posedge clk);
    endtask

    task automatic stream_idle();
        s_valid = 1'b0; s_sop = 1'b0; s_eop = 1'b0; s_last = 1'b0;
        s_addr_perr = 1'b0; s_data_perr = 1'b0; s_pkt_err = 1'b0;
    endtask

    // checks R5 after the final byte
    task automatic finish_frag();
        @(negedge clk);
        stream_idle();
        check("R5 event high", cap_event, 1);
        check("R5 data_avail with event", data_avail, 1);
        check("R6 ready low when held", s_ready, 0);
        @(negedge clk);
        check("R5 event one cycle", cap_event, 0);
    endtask

    task automatic send_frag(input int n, input logic [7:0] seed, input logic [7:0] ch,
                             input logic sop, input logic eop, input logic mark_last);
        for (int i = 0; i < n; i++) begin
            push(pat(seed, i), ch, sop && (i == 0), eop && (i == n - 1),
                 mark_last && (i == n - 1), 3'b000);
        end
        finish_frag();
    endtask

    task automatic host_read(input int addr, output logic [7:0] val);
        @(negedge clk);
        h_rd_en = 1'b1; h_rd_addr = 9'(addr);
        @(posedge clk);
        @(negedge clk);
        h_rd_en = 1'b0;
        val = h_rd_data;
    endtask

    task automatic host_release();
        @(negedge clk);
        h_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        h_clr = 1'b0;
        check("R9 data_avail cleared", data_avail, 0);
        check("R9 ready restored", s_ready, 1);
    endtask

    task automatic t_reset();
        check("R1 ready after reset", s_ready, 1);
        check("R1 data_avail after reset", data_avail, 0);
        check("R1 event after reset", cap_event, 0);
    endtask

    task automatic t_short();
        logic [7:0] v;
        send_frag(5, 8'h51, 8'h2A, 1'b1, 1'b1, 1'b0);
        host_read(1, v); check("R3 length of 5-byte fragment", v, 4);
        host_read(2, v); check("R7 channel", v, 8'h2A);
        host_read(0, v); check("R8 flags SOP+EOP", v, 8'h03);
        for (int i = 0; i < 5; i++) begin
            host_read(3 + i, v); check("R2 payload byte", v, pat(8'h51, i));
        end
    endtask

    task automatic t_held_ignore();
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            push(8'hEE, 8'h77, 1'b0, 1'b0, 1'b1, 3'b111);
            @(negedge clk);
            check("R6 ready held low", s_ready, 0);
        end
        stream_idle();
        host_read(3, v); check("R6 payload unchanged", v, pat(8'h51, 0));
        host_read(0, v); check("R6 flags unchanged", v, 8'h03);
        host_read(2, v); check("R6 channel unchanged", v, 8'h2A);
        host_read(1, v); check("R6 length unchanged", v, 4);
        check("R6 still held", data_avail, 1);
    endtask

    task automatic t_idle_read();
        logic [7:0] v;
        host_read(3, v); check("R11 read with no fragment", v, 0);
        host_read(2, v); check("R11 channel read with no fragment", v, 0);
    endtask

    task automatic t_full();
        logic [7:0] v;
        send_frag(256, 8'h9C, 8'h05, 1'b0, 1'b0, 1'b0);
        host_read(1, v); check("R4 length of full fragment", v, 8'hFF);
        host_read(3, v); check("R4 first byte", v, pat(8'h9C, 0));
        host_read(258, v); check("R4 last byte", v, pat(8'h9C, 255));
        host_read(0, v); check("R9 flags cleared by release", v, 8'h00);
        host_read(259, v); check("R12 read past payload", v, 0);
        host_read(511, v); check("R12 read at top address", v, 0);
    endtask

    task automatic t_errors();
        logic [7:0] v;
        for (int i = 0; i < 10; i++) begin
            push(pat(8'h33, i), 8'hC4, 1'b0, 1'b0, i == 9,
                 (i == 2) ? 3'b001 : (i == 5) ? 3'b010 : (i == 9) ? 3'b100 : 3'b000);
        end
        finish_frag();
        host_read(0, v); check("R8 sticky error flags", v, 8'h1C);
        host_read(1, v); check("R3 length ended by last marker", v, 9);
        host_read(2, v); check("R7 channel of error fragment", v, 8'hC4);
    endtask

    task automatic t_clr_ignored();
        logic [7:0] v;
        @(negedge clk);
        h_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        h_clr = 1'b0;
        check("R10 clear in idle keeps ready", s_ready, 1);
        for (int i = 0; i < 7; i++) begin
            if (i == 3) h_clr = 1'b1;
            push(pat(8'h6D, i), 8'h11, i == 0, 1'b0, i == 6, 3'b000);
            h_clr = 1'b0;
        end
        finish_frag();
        host_read(1, v); check("R10 length after clear in fill", v, 6);
        host_read(3 + 6, v); check("R10 last payload byte", v, pat(8'h6D, 6));
        host_read(0, v); check("R10 flags", v, 8'h01);
    endtask

    task automatic t_one_byte();
        logic [7:0] v;
        send_frag(1, 8'hA0, 8'hFE, 1'b1, 1'b1, 1'b1);
        host_read(1, v); check("R3 one-byte length", v, 0);
        host_read(3, v); check("R2 single payload byte", v, pat(8'hA0, 0));
        host_read(2, v); check("R7 channel one-byte", v, 8'hFE);
    endtask

    initial begin
        #2000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_held_ignore();
        host_release();
        t_idle_read();
        t_full();
        host_release();
        t_errors();
        host_release();
        t_clr_ignored();
        host_release();
        t_one_byte();
        host_release();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule